// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, once per cycle, which hardware thread contexts of a simultaneous multithreading core may fetch instructions. Each thread reports a ready flag together with four occupancy counters: instructions waiting in the front end and queues, unresolved branches, outstanding data-cache misses, and how long its oldest queue entry has waited. A policy input chooses which counter ranks the threads. When a fetch request is raised, up to GRANTS ready threads with the smallest counter value are granted. Each granted thread receives a fetch budget of BUDGET instructions.

A rotation pointer breaks ties. Among threads with equal counter values, the thread nearest the pointer in increasing index order (wrapping) wins. After any cycle with at least one grant, the pointer moves to one past the lowest-priority thread that was granted. In the rotate policy every counter is treated as equal, so the pointer alone orders the threads and fetch cycles through them. Grants and budgets are registered: they appear on the outputs one cycle after the inputs are sampled.

Top module: `fetch_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, fetch_grant and every fetch_budget field are zero, and the rotation pointer starts at thread 0.
- R2: A cycle with fetch_req low produces an all-zero grant one cycle later and leaves the rotation pointer unchanged.
- R3: A thread whose thr_ready bit is low is never granted.
- R4: With fetch_req high, the number of grant bits set one cycle later equals the smaller of GRANTS and the number of ready threads.
- R5: Policy code 1 ranks ready threads by smallest pend_cnt.
- R6: Policy code 2 ranks by smallest br_cnt, and policy code 3 ranks by smallest miss_cnt.
- R7: Policy code 4 ranks by smallest age_cnt, so the thread whose oldest entry has waited longest is granted last.
- R8: Policy code 0 and the unused codes 5 to 7 ignore all counters. Threads are granted in rotation order from the pointer.
- R9: Equal counter values are ordered by the distance (index minus pointer, modulo NTHR). After any cycle with a grant, the pointer becomes one past the granted thread of lowest priority, wrapping from NTHR-1 to 0.
- R10: The fetch_budget field of a granted thread equals BUDGET, and the field of every other thread is zero, in the same cycle as the grant.
- R11: Outputs are registered. An input change becomes visible only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | A fetch slot is available this cycle |
| policy | input | 3 | Ranking policy code (0 rotate, 1 pending, 2 branch, 3 miss, 4 age) |
| thr_ready | input | NTHR | Per-thread eligibility |
| pend_cnt | input | NTHR x CW | Per-thread count of pending front-end instructions |
| br_cnt | input | NTHR x CW | Per-thread count of unresolved branches |
| miss_cnt | input | NTHR x CW | Per-thread count of outstanding data misses |
| age_cnt | input | NTHR x CW | Per-thread wait time of the oldest queue entry |
| fetch_grant | output | NTHR | Registered grant vector, up to GRANTS bits set |
| fetch_budget | output | NTHR x BW | Registered per-thread instruction budget |

## Verification
The rotate policy is run over many cycles with all threads ready and then with counters that vary. This shows that the pointer alone orders threads and that the counters are ignored. Each counter policy is given the same set of distinct counter values in a different arrangement, so that a mix-up between counter inputs selects a different pair of threads. Runs with every counter equal separate the tie-break and pointer-advance rule from the ranking. Runs with one ready thread and with no ready thread check the grant count limit and confirm that the pointer holds when nothing is granted.

// File: rtl/fetch_sel_pkg.sv
package fetch_sel_pkg;
  typedef enum logic [2:0] {
    POL_ROTATE = 3'd0,
    POL_PEND   = 3'd1,
    POL_BRANCH = 3'd2,
    POL_MISS   = 3'd3,
    POL_AGE    = 3'd4
  } policy_e;
endpackage

// File: rtl/fetch_key_mux.sv
module fetch_key_mux #(
  parameter int NTHR = 8,
  parameter int CW   = 6
) (
  input  logic [2:0]                 policy,
  input  logic [NTHR-1:0][CW-1:0]    pend_cnt,
  input  logic [NTHR-1:0][CW-1:0]    br_cnt,
  input  logic [NTHR-1:0][CW-1:0]    miss_cnt,
  input  logic [NTHR-1:0][CW-1:0]    age_cnt,
  output logic [NTHR-1:0][CW-1:0]    rank_key
);
  import fetch_sel_pkg::*;

  // One selector per thread; the rotate policy and unused codes yield key 0
  for (genvar t = 0; t < NTHR; t++) begin : g_key
    always_comb begin
      case (policy)
        POL_PEND:   rank_key[t] = pend_cnt[t];
        POL_BRANCH: rank_key[t] = br_cnt[t];
        POL_MISS:   rank_key[t] = miss_cnt[t];
        POL_AGE:    rank_key[t] = age_cnt[t];
        default:    rank_key[t] = '0;
      endcase
    end
  end
endmodule

// File: rtl/fetch_rank_sel.sv
module fetch_rank_sel #(
  parameter int NTHR   = 8,
  parameter int CW     = 6,
  parameter int GRANTS = 2,
  localparam int PW    = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic [NTHR-1:0]            ready,
  input  logic [NTHR-1:0][CW-1:0]    rank_key,
  input  logic [PW-1:0]              ptr,
  output logic [NTHR-1:0]            sel,
  output logic [PW-1:0]              last_idx,
  output logic                       any_sel
);
  // Rotation distance of thread idx from the pointer
  function automatic int rot_dist(input int idx, input int p);
    return (idx + NTHR - p) % NTHR;
  endfunction

  // True when thread a ranks strictly ahead of thread b
  function automatic bit ahead(input logic [CW-1:0] ka, input int da,
                               input logic [CW-1:0] kb, input int db);
    return (ka < kb) || ((ka == kb) && (da < db));
  endfunction

  int rank [NTHR];
  int nready;
  int nsel;

  // Rank of each thread = number of ready threads ahead of it
  always_comb begin
    for (int i = 0; i < NTHR; i++) begin
      rank[i] = 0;
      for (int j = 0; j < NTHR; j++) begin
        if ((j != i) && ready[j] &&
            ahead(rank_key[j], rot_dist(j, int'(ptr)),
                  rank_key[i], rot_dist(i, int'(ptr))))
          rank[i] = rank[i] + 1;
      end
    end
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_sel
    assign sel[t] = ready[t] && (rank[t] < GRANTS);
  end

  // Lowest-priority granted thread sets the next pointer
  always_comb begin
    nready = 0;
    for (int i = 0; i < NTHR; i++) nready = nready + int'(ready[i]);
    nsel = (nready > GRANTS) ? GRANTS : nready;
    last_idx = '0;
    for (int i = 0; i < NTHR; i++) begin
      if (sel[i] && (rank[i] == nsel - 1)) last_idx = PW'(i);
    end
  end

  assign any_sel = |sel;
endmodule

// File: rtl/fetch_rr_ptr.sv
module fetch_rr_ptr #(
  parameter int NTHR = 8,
  localparam int PW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic [PW-1:0] last_idx,
  output logic [PW-1:0] ptr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (advance)
      ptr_q <= (last_idx == PW'(NTHR - 1)) ? '0 : last_idx + 1'b1;
  end
endmodule

// File: rtl/fetch_sel.sv
module fetch_sel #(
  parameter int NTHR   = 8,
  parameter int GRANTS = 2,
  parameter int BUDGET = 4,
  parameter int CW     = 6,
  localparam int BW    = $clog2(BUDGET + 1),
  localparam int PW    = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fetch_req,
  input  logic [2:0]                 policy,
  input  logic [NTHR-1:0]            thr_ready,
  input  logic [NTHR-1:0][CW-1:0]    pend_cnt,
  input  logic [NTHR-1:0][CW-1:0]    br_cnt,
  input  logic [NTHR-1:0][CW-1:0]    miss_cnt,
  input  logic [NTHR-1:0][CW-1:0]    age_cnt,
  output logic [NTHR-1:0]            fetch_grant,
  output logic [NTHR-1:0][BW-1:0]    fetch_budget
);
  localparam logic [BW-1:0] BUDGET_V = BW'(BUDGET);

  // Named internal events
  logic [NTHR-1:0][CW-1:0] rank_key;
  logic [NTHR-1:0]         sel_next;
  logic [PW-1:0]           last_idx;
  logic                    any_sel;
  logic                    ptr_adv;
  logic [PW-1:0]           ptr_q;

  fetch_key_mux #(.NTHR(NTHR), .CW(CW)) u_key (
    .policy   (policy),
    .pend_cnt (pend_cnt),
    .br_cnt   (br_cnt),
    .miss_cnt (miss_cnt),
    .age_cnt  (age_cnt),
    .rank_key (rank_key)
  );

  fetch_rank_sel #(.NTHR(NTHR), .CW(CW), .GRANTS(GRANTS)) u_rank (
    .ready    (thr_ready),
    .rank_key (rank_key),
    .ptr      (ptr_q),
    .sel      (sel_next),
    .last_idx (last_idx),
    .any_sel  (any_sel)
  );

  assign ptr_adv = fetch_req && any_sel;

  fetch_rr_ptr #(.NTHR(NTHR)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (ptr_adv),
    .last_idx (last_idx),
    .ptr_q    (ptr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_grant  <= '0;
      fetch_budget <= '0;
    end else begin
      fetch_grant <= fetch_req ? sel_next : '0;
      for (int t = 0; t < NTHR; t++)
        fetch_budget[t] <= (fetch_req && sel_next[t]) ? BUDGET_V : '0;
    end
  end
endmodule

// File: rtl/fetch_sel_chk.sv
module fetch_sel_chk #(
  parameter int NTHR   = 8,
  parameter int GRANTS = 2,
  parameter int BUDGET = 4,
  parameter int BW     = 3,
  parameter int PW     = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    fetch_req,
  input logic [NTHR-1:0]         thr_ready,
  input logic [NTHR-1:0]         fetch_grant,
  input logic [NTHR-1:0][BW-1:0] fetch_budget,
  input logic [PW-1:0]           ptr_q
);
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_req |=> (fetch_grant == '0)); // R2

  AST_IDLE_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_req |=> $stable(ptr_q)); // R2

  AST_READY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> ((fetch_grant & ~$past(thr_ready)) == '0)); // R3

  AST_GRANT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> ($countones(fetch_grant) ==
      (($countones($past(thr_ready)) > GRANTS) ? GRANTS
                                               : $countones($past(thr_ready))))); // R4

  for (genvar t = 0; t < NTHR; t++) begin : g_bud
    AST_BUDGET_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_budget[t] == (fetch_grant[t] ? BW'(BUDGET) : '0)); // R10
  end
endmodule

bind fetch_sel fetch_sel_chk #(
  .NTHR(NTHR), .GRANTS(GRANTS), .BUDGET(BUDGET), .BW(BW), .PW(PW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetch_req    (fetch_req),
  .thr_ready    (thr_ready),
  .fetch_grant  (fetch_grant),
  .fetch_budget (fetch_budget),
  .ptr_q        (ptr_q)
);

// File: tb/sim_fetch_sel.sv
`timescale 1ns/1ps
module sim_fetch_sel;
  localparam int N  = 8;
  localparam int X  = 2;
  localparam int Y  = 4;
  localparam int CW = 6;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_req = 1'b0;
  logic [2:0] policy = 3'd0;
  logic [N-1:0] thr_ready = '0;
  logic [N-1:0][CW-1:0] pend_cnt = '0, br_cnt = '0, miss_cnt = '0, age_cnt = '0;
  logic [N-1:0] fetch_grant;
  logic [N-1:0][BW-1:0] fetch_budget;

  always #2.5 clk = ~clk;

  fetch_sel #(.NTHR(N), .GRANTS(X), .BUDGET(Y), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .policy(policy),
    .thr_ready(thr_ready), .pend_cnt(pend_cnt), .br_cnt(br_cnt),
    .miss_cnt(miss_cnt), .age_cnt(age_cnt),
    .fetch_grant(fetch_grant), .fetch_budget(fetch_budget)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int mptr    = 0;
  logic [N-1:0] prev_g = '0;
  logic [N-1:0] q_g [$];
  string        q_tag [$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int key_of(input int pol, input int t);
    case (pol)
      1: return int'(pend_cnt[t]);
      2: return int'(br_cnt[t]);
      3: return int'(miss_cnt[t]);
      4: return int'(age_cnt[t]);
      default: return 0;
    endcase
  endfunction

  // Reference: repeated pick of the best remaining ready thread
  function automatic logic [N-1:0] predict(input bit rq, input int pol, input logic [N-1:0] rdy);
    logic [N-1:0] picked = '0;
    int last = -1;
    if (!rq) return '0;
    for (int s = 0; s < X; s++) begin
      int best = -1;
      int bscore = 0;
      for (int t = 0; t < N; t++) begin
        if (rdy[t] && !picked[t]) begin
          int sc = key_of(pol, t) * N + ((t - mptr + N) % N);
          if (best < 0 || sc < bscore) begin best = t; bscore = sc; end
        end
      end
      if (best >= 0) begin picked[best] = 1'b1; last = best; end
    end
    if (last >= 0) mptr = (last + 1) % N;
    return picked;
  endfunction

  // Driver: apply one cycle of stimulus and queue the expected grant
  task automatic drive(input bit rq, input int pol, input logic [N-1:0] rdy, input string tag);
    logic [N-1:0] g;
    @(negedge clk);
    fetch_req = rq;
    policy    = 3'(pol);
    thr_ready = rdy;
    #1;
    check(fetch_grant == prev_g, "R11 output changed before clock edge", 32'(fetch_grant), 32'(prev_g));
    g = predict(rq, pol, rdy);
    q_g.push_back(g);
    q_tag.push_back(tag);
    prev_g = g;
  endtask

  task automatic idle();
    drive(1'b0, int'(policy), thr_ready, "R2 idle cycle");
  endtask

  // Monitor: compare the registered outputs against the queue
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_g.size() > 0) begin
        logic [N-1:0] eg;
        string tg;
        eg = q_g.pop_front();
        tg = q_tag.pop_front();
        check(fetch_grant == eg, tg, 32'(fetch_grant), 32'(eg));
        for (int t = 0; t < N; t++) begin
          logic [BW-1:0] eb;
          eb = eg[t] ? BW'(Y) : '0;
          check(fetch_budget[t] == eb, "R10 budget field", 32'(fetch_budget[t]), 32'(eb));
        end
      end
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(fetch_grant == '0, "R1 grant in reset", 32'(fetch_grant), 32'h0);
    check(fetch_budget == '0, "R1 budget in reset", 32'(fetch_budget), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(fetch_grant == '0, "R1 grant after reset", 32'(fetch_grant), 32'h0);

    // Idle with all ready: no grant, pointer stays at 0
    drive(1'b0, 0, 8'hFF, "R2 request low");
    // Rotation from pointer 0 confirms R1 start and R2 hold
    for (int k = 0; k < 5; k++) drive(1'b1, 0, 8'hFF, "R8 rotate all ready");
    // Rotation ignores counters
    for (int t = 0; t < N; t++) begin
      pend_cnt[t] = CW'(N - t); br_cnt[t] = CW'(t); miss_cnt[t] = CW'(3 * t % 7); age_cnt[t] = CW'(t * 5 % 8);
    end
    for (int k = 0; k < 3; k++) drive(1'b1, 0, 8'hFF, "R8 rotate ignores counts");
    drive(1'b1, 0, 8'b1010_0110, "R3 rotate partial ready");
    idle();
    // Same distinct values, arranged differently per counter
    pend_cnt = {6'd6, 6'd2, 6'd8, 6'd5, 6'd1, 6'd7, 6'd3, 6'd9};
    br_cnt   = {6'd1, 6'd9, 6'd3, 6'd7, 6'd6, 6'd2, 6'd8, 6'd5};
    miss_cnt = {6'd9, 6'd5, 6'd1, 6'd3, 6'd8, 6'd6, 6'd2, 6'd7};
    age_cnt  = {6'd3, 6'd7, 6'd6, 6'd2, 6'd9, 6'd1, 6'd5, 6'd8};
    drive(1'b1, 1, 8'hFF, "R5 pending policy");
    drive(1'b1, 1, 8'b1011_0111, "R3 pending policy best thread not ready");
    idle();
    drive(1'b1, 2, 8'hFF, "R6 branch policy");
    idle();
    drive(1'b1, 3, 8'hFF, "R6 miss policy");
    idle();
    drive(1'b1, 4, 8'hFF, "R7 age policy");
    drive(1'b1, 4, 8'b0101_1111, "R7 age policy partial ready");
    idle();
    // All counters equal: pointer decides, pointer advances
    pend_cnt = '0;
    for (int t = 0; t < N; t++) pend_cnt[t] = 6'd4;
    for (int k = 0; k < 4; k++) drive(1'b1, 1, 8'hFF, "R9 ties by pointer");
    drive(1'b1, 1, 8'b1000_0001, "R9 tie wrap");
    drive(1'b1, 1, 8'b0001_0000, "R4 single ready thread");
    drive(1'b1, 1, 8'h00, "R4 no ready thread");
    drive(1'b1, 1, 8'hFF, "R9 pointer held after empty grant");
    idle();
    for (int k = 0; k < 3; k++) drive(1'b1, 6, 8'hFF, "R8 unused code rotates");
    idle();
    repeat (3) @(posedge clk);
    #1;
    summary();
    $finish;
  end
endmodule